// File: doc/BRIEF.md
# Timer event status flag register

This block holds the event flags of a timer that has four capture/compare channels and a free-running counter. Each channel flag latches when its channel reports an event. In capture mode that event is the capture edge strobe. In compare mode, which also covers the PWM variants, it is the counter-equals-register match strobe. A fifth flag latches when the counter wraps.

Software reads the flags through a simple synchronous register port. A flag can only be cleared by writing 0 to it, and only after a read has returned that flag as 1. Each flag carries an armed bit. Every read loads the armed bit with the flag's current value, and the next write uses that bit up. An event that lands between the read and the clearing write is therefore never lost.

When channels C and D act as buffers for A and B, their match strobes still set their own flags. The block applies no masking here. Read data comes straight from the flag state, with no added latency.

Top module: `tmr_evt_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data reads 8'h70. All flags are clear and bits 6..4 are 1.
- R2: Bits 6..4 of rd_data always read 1, and writing any value to them has no effect.
- R3: With mode_capture = 1, cap_edge[i] (i = 0..3, channel A..D at bit i) sets flag bit i at the next clock edge, and cmp_match has no effect.
- R4: With mode_capture = 0, cmp_match[i] sets flag bit i at the next clock edge, and cap_edge has no effect.
- R5: ovf_strobe sets flag bit 7 at the next clock edge, in either mode.
- R6: A write (wr_en = 1) with wr_data bit i = 0 clears flag bit i at that edge when the most recent read since the previous write returned bit i as 1.
- R7: A write of 0 to a flag bit that last read as 0, or that was not read since the previous write, leaves the bit unchanged. This holds when the bit became 1 after the read.
- R8: Writing 1 to any flag bit leaves that bit unchanged.
- R9: Any write discards the read-as-1 record of every bit, so a second write of 0 without a new read clears nothing. When rd_en and wr_en are both high, the record is reloaded from the read.
- R10: If a set event and a qualified clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R11: With no event and no write, every flag keeps its value. rd_en alone changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_capture | input | 1 | 1: channels flag on capture edges; 0: on compare matches |
| cap_edge | input | 4 | Per-channel capture edge strobes, bit i = channel i |
| cmp_match | input | 4 | Per-channel compare match strobes, bit i = channel i |
| ovf_strobe | input | 1 | Counter overflow strobe |
| rd_en | input | 1 | Register read strobe, arms bits that read as 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; 0 in a flag position requests a clear |
| rd_data | output | 8 | Current register value |

## Verification
On every cycle, the assertions check several rules. A flag can only fall after a write that carried 0 for it. An enabled event always shows as a set flag one cycle later. The padding bits stay at 1. A checker-side record of the read-as-1 state decides when a write-0 must clear a bit and when it must not. Some behaviours need ordered stimulus that only the bench scenarios supply. These are an event landing between a read and a write, a second clear without a fresh read, a write of 1 after an arming read, and a set colliding with a clear. The bench also compares every cycle against its own reference model under random traffic.

// File: rtl/tmr_evt_pkg.sv
// Package: shared constants for the timer event status register.
// Assumes an 8-bit register with channel flags in the low bits and the
// overflow flag in the top bit; the rest is padding that reads as 1.
package tmr_evt_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_CH   = 4;
    localparam int OVF_BIT  = REG_W - 1;
    localparam int PAD_LO   = NUM_CH;
    localparam int PAD_HI   = OVF_BIT - 1;
    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << OVF_BIT) | ((REG_W'(1) << NUM_CH) - REG_W'(1));
    localparam logic [REG_W-1:0] PAD_MASK = ~FLAG_MASK;
    localparam logic [REG_W-1:0] RESET_VAL = PAD_MASK;
endpackage

// File: rtl/tmr_evt_src_sel.sv
// Module: picks the set source of each channel flag.
// Assumes strobes are single-cycle pulses already qualified upstream
// (edge selection and compare are done elsewhere).
module tmr_evt_src_sel #(
    parameter int NUM_CH = 4
) (
    input  logic              mode_capture,
    input  logic [NUM_CH-1:0] cap_edge,
    input  logic [NUM_CH-1:0] cmp_match,
    output logic [NUM_CH-1:0] ch_set
);
    // Route either capture edges or compare matches to each channel flag.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_set[g] = mode_capture ? cap_edge[g] : cmp_match[g];
    end
endmodule

// File: rtl/tmr_evt_flag_cell.sv
// Module: one status flag with a read-as-1 armed bit.
// The armed bit loads the flag on a read and is dropped on a write
// (a simultaneous read reloads it). A write with data 0 clears the flag
// only when armed; a set in the same cycle overrides the clear.
module tmr_evt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    logic armed;
    logic clr;

    // Qualified clear: write of 0 to a bit last read as 1.
    assign clr = wr_i && !wr_bit_i && armed;

    // Flag state: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= set_i | (flag_o & ~clr);
    end

    // Armed bit: captured on read, discarded on write.
    always_ff @(posedge clk) begin
        if (!rst_n)    armed <= 1'b0;
        else if (rd_i) armed <= flag_o;
        else if (wr_i) armed <= 1'b0;
    end
endmodule

// File: rtl/tmr_evt_status.sv
// Module: timer event status register (top).
// Holds four channel flags and one overflow flag; padding bits read 1.
// Assumes the bus port is synchronous: rd_en/wr_en are one-cycle strobes
// sampled at the rising edge, and rd_data is valid combinationally.
module tmr_evt_status
    import tmr_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_capture,
    input  logic [NUM_CH-1:0] cap_edge,
    input  logic [NUM_CH-1:0] cmp_match,
    input  logic              ovf_strobe,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data
);
    logic [NUM_CH-1:0] ch_set;
    logic [REG_W-1:0]  set_vec;
    logic [REG_W-1:0]  flag_vec;

    tmr_evt_src_sel #(.NUM_CH(NUM_CH)) u_src (
        .mode_capture (mode_capture),
        .cap_edge     (cap_edge),
        .cmp_match    (cmp_match),
        .ch_set       (ch_set)
    );

    // Build the per-bit set vector and a flag cell for each flag position.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b < NUM_CH) begin : g_ch
            assign set_vec[b] = ch_set[b];
        end else if (b == OVF_BIT) begin : g_ovf
            assign set_vec[b] = ovf_strobe;
        end else begin : g_pad
            assign set_vec[b] = 1'b0;
        end

        if (FLAG_MASK[b]) begin : g_cell
            tmr_evt_flag_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (set_vec[b]),
                .rd_i     (rd_en),
                .wr_i     (wr_en),
                .wr_bit_i (wr_data[b]),
                .flag_o   (flag_vec[b])
            );
        end else begin : g_tie
            assign flag_vec[b] = 1'b1;
        end
    end

    // Read path: flags straight out, padding forced to 1.
    assign rd_data = (flag_vec & FLAG_MASK) | PAD_MASK;
endmodule

// File: rtl/tmr_evt_status_chk.sv
// Checker: port-level properties of tmr_evt_status, bound to every instance.
// Keeps its own read-as-1 record to judge write-0 outcomes.
module tmr_evt_status_chk
    import tmr_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_capture,
    input logic [NUM_CH-1:0] cap_edge,
    input logic [NUM_CH-1:0] cmp_match,
    input logic              ovf_strobe,
    input logic              rd_en,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data
);
    logic [REG_W-1:0] seen_one;

    // Shadow of the read-as-1 record.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_one <= '0;
        else if (rd_en) seen_one <= rd_data & FLAG_MASK;
        else if (wr_en) seen_one <= '0;
    end

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> rd_data == RESET_VAL);

    assert_pad_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & PAD_MASK) == PAD_MASK);

    assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_strobe |=> rd_data[OVF_BIT]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_capture_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_capture && cap_edge[c]) |=> rd_data[c]);
        assert_compare_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_capture && cmp_match[c]) |=> rd_data[c]);
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_flag
        if (FLAG_MASK[b]) begin : g_on
            assert_fall_needs_write0_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rd_data[b]) |-> $past(wr_en && !wr_data[b] && seen_one[b]));
            assert_unarmed_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !seen_one[b] && rd_data[b]) |=> rd_data[b]);
            assert_armed_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !wr_data[b] && seen_one[b] && !ovf_strobe && !cap_edge[b % NUM_CH]
                 && !cmp_match[b % NUM_CH]) |=> !rd_data[b]);
        end
    end
endmodule

bind tmr_evt_status tmr_evt_status_chk u_chk (.*);

// File: tb/tmr_evt_status_bench.sv
module tmr_evt_status_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_capture = 1'b1;
    logic [3:0] cap_edge = '0;
    logic [3:0] cmp_match = '0;
    logic       ovf_strobe = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit model_on = 0;
    bit [7:0] m_flag = '0;
    bit [7:0] m_arm = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_evt_status u_tmr_evt_status (.*);

    // Behavioural reference model, one update per clock.
    always @(posedge clk) begin
        bit [7:0] nf;
        bit [7:0] na;
        if (!rst_n) begin
            nf = '0; na = '0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                bit s, c;
                if (i < 4) s = mode_capture ? cap_edge[i] : cmp_match[i];
                else       s = (i == 7) ? ovf_strobe : 1'b0;
                c = wr_en && !wr_data[i] && m_arm[i];
                nf[i] = (i >= 4 && i <= 6) ? 1'b0 : (s | (m_flag[i] & !c));
                na[i] = rd_en ? m_flag[i] : (wr_en ? 1'b0 : m_arm[i]);
            end
        end
        m_flag <= nf;
        m_arm  <= na;
    end

    // Per-cycle model comparison (R11 covers hold behaviour under traffic).
    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (rd_data !== (m_flag | 8'h70)) begin
                errors++;
                $display("FAIL model R11: got %h expected %h", rd_data, m_flag | 8'h70);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
        end
    endtask

    // Drive one cycle of stimulus starting at a negedge; returns at the next negedge.
    task automatic cyc(input logic [3:0] ce, input logic [3:0] cm, input logic ov,
                       input logic rd, input logic wr, input logic [7:0] wd);
        cap_edge = ce; cmp_match = cm; ovf_strobe = ov;
        rd_en = rd; wr_en = wr; wr_data = wd;
        @(negedge clk);
        cap_edge = '0; cmp_match = '0; ovf_strobe = 1'b0;
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset value", 8'h70);
        model_on = 1;

        mode_capture = 1'b1;
        cyc(4'b0001, 4'b0000, 0, 0, 0, 8'h00); chk("R3 capture sets A", 8'h71);
        cyc(4'b0000, 4'b0010, 0, 0, 0, 8'h00); chk("R3 match ignored in capture", 8'h71);
        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00); chk("R11 read alone holds", 8'h71);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R6 armed write0 clears", 8'h70);
        chk("R2 pad bits unchanged by write0", 8'h70);

        mode_capture = 1'b0;
        cyc(4'b0000, 4'b0100, 0, 0, 0, 8'h00); chk("R4 compare sets C", 8'h74);
        cyc(4'b1000, 4'b0000, 0, 0, 0, 8'h00); chk("R4 edge ignored in compare", 8'h74);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R7 write0 without read", 8'h74);

        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00);
        cyc(4'b0000, 4'b1000, 0, 0, 0, 8'h00); chk("R4 compare sets D", 8'h7C);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R7 set after read survives", 8'h78);

        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'hFF); chk("R8 write1 keeps D", 8'h78);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R9 record dropped by write", 8'h78);
        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R6 clear D", 8'h70);

        cyc(4'b0000, 4'b0000, 1, 0, 0, 8'h00); chk("R5 overflow sets b7", 8'hF0);
        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h7F); chk("R6 clear b7, R2 pad write", 8'h70);

        cyc(4'b0000, 4'b0010, 0, 0, 0, 8'h00);
        cyc(4'b0000, 4'b0000, 0, 1, 0, 8'h00);
        cyc(4'b0000, 4'b0010, 0, 0, 1, 8'h00); chk("R10 set beats clear", 8'h72);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R9 no second clear", 8'h72);
        cyc(4'b0000, 4'b0000, 0, 1, 1, 8'h00); chk("R9 read+write no clear", 8'h72);
        cyc(4'b0000, 4'b0000, 0, 0, 1, 8'h00); chk("R9 reloaded record clears", 8'h70);
        repeat (4) cyc(4'b0000, 4'b0000, 0, 0, 0, 8'h00);
        chk("R11 idle hold", 8'h70);

        for (int n = 0; n < 600; n++) begin
            mode_capture = $urandom_range(1, 0);
            cyc(4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom),
                ($urandom_range(7, 0) == 0), $urandom_range(1, 0),
                $urandom_range(1, 0), 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule